// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog timer configured through one control byte. The low two bits of the byte pick a resolution and the next five bits a multiplier. Together they set how many periods of an external 1/16-second tick may pass before the watchdog expires. The top bit steers the expiry. When it is set, the expiry raises a system reset request. When it is clear, the expiry pulses an interrupt. A timeout flag records that the watchdog has expired. Software keeps the watchdog alive by writing the control byte again or simply reading it. Both restart the count.

Commands arrive on a valid/ready port. `cmd_ready` is always high, so every cycle with `cmd_valid` high moves one command, either a write or a read, and the port never applies back-pressure. A read returns the stored byte on `rsp_valid`/`rsp_rdata` one clock later. That response has no ready of its own, so the consumer must take it in the cycle it appears. A reset-steered expiry also zeroes the control byte. It also pulses `cent_clr` so that the neighbouring calendar logic can drop its century-enable bit.

Top module: `wdt_encoded`

## Requirements
- R1: Control bits [1:0] are the resolution and bits [6:2] the multiplier. The interval is multiplier × 4^resolution tick periods. The expiry pulse appears on the clock after the interval-th tick that follows a restart.
- R2: When the interval decodes to zero, the watchdog is disabled and no amount of ticking causes an expiry. This covers a written value of 0x00 and any multiplier of zero.
- R3: A write stores the byte, clears `tmo_flag` on the next clock, and restarts the count from the newly written interval.
- R4: A read returns the stored byte with `rsp_valid` high on the next clock. It restarts the count from the stored interval and leaves `tmo_flag` unchanged.
- R5: An expiry sets `tmo_flag`, which then stays set until the next write.
- R6: With bit 7 set, an expiry gives a one-clock `rst_req` together with a one-clock `cent_clr`, and the stored byte becomes 0x00, as a later read shows.
- R7: With bit 7 clear, an expiry gives a one-clock `irq` and leaves the stored byte unchanged. `irq` and `rst_req` are never high together.
- R8: After an expiry the count stops, and further ticks produce no more pulses until a read or write restarts it.
- R9: A command accepted in the same clock as the final tick wins: the count restarts and no expiry occurs.
- R10: `cmd_ready` is always high, so a command is accepted in every clock where `cmd_valid` is high.
- R11: After reset the stored byte is 0x00 (disabled) and `tmo_flag`, `rst_req`, `irq`, `cent_clr` and `rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe per 1/16 second |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 8 | Byte to store on a write |
| rsp_valid | output | 1 | Read data valid (one clock) |
| rsp_rdata | output | 8 | Stored control byte |
| rst_req | output | 1 | Reset-request pulse on steered expiry |
| irq | output | 1 | Interrupt pulse on unsteered expiry |
| cent_clr | output | 1 | Pulse telling neighbouring logic to clear its century-enable bit |
| tmo_flag | output | 1 | Timeout flag |

## Verification
Two functions can fall in the same clock: a restart by a command, and the final tick that would otherwise expire the count. The bench arranges for a read or write with `tick` high to land exactly when the remaining count is one. It then expects no pulse on the next clock, followed by a full fresh interval. A per-clock behavioural model, which tracks the remaining count as a plain integer, judges every output in every cycle. This includes the cycles around that collision.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // How an expiry is routed, chosen by the top bit of the control byte.
  typedef enum logic {
    STEER_IRQ = 1'b0,
    STEER_RST = 1'b1
  } steer_e;

  // An expiry event as handed from the counter to the steering stage.
  typedef struct packed {
    logic   fire;
    steer_e route;
  } expiry_t;

endpackage

// File: rtl/wdt_decode.sv
module wdt_decode #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int CFG_W = 1 + MULT_W + RES_W,
  localparam int RES_N = 1 << RES_W,
  localparam int CNT_W = MULT_W + 2 * (RES_N - 1)
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [CNT_W-1:0] ticks,
  output logic             zero
);

  logic [RES_W-1:0]  res;
  logic [MULT_W-1:0] mult;
  logic [CNT_W-1:0]  cand [RES_N];

  assign res  = cfg[RES_W-1:0];
  assign mult = cfg[RES_W +: MULT_W];

  // One shifted copy of the multiplier per resolution step (4^r).
  for (genvar r = 0; r < RES_N; r++) begin : g_scale
    assign cand[r] = CNT_W'(mult) << (2 * r);
  end

  assign ticks = cand[res];
  assign zero  = (mult == '0);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] load,
  input  logic             load_zero,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             last;

  assign last   = (cnt_q == CNT_W'(1));
  assign expire = run_q && tick && last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= load;
      run_q <= !load_zero;
    end else if (run_q && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last) begin
        run_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdt_regif.sv
module wdt_regif #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [CFG_W-1:0] cmd_wdata,
  input  logic             clr_cfg,
  output logic [CFG_W-1:0] cfg,
  output logic [CFG_W-1:0] load_cfg,
  output logic             restart,
  output logic             wr_evt,
  output logic             rsp_valid,
  output logic [CFG_W-1:0] rsp_rdata
);

  logic [CFG_W-1:0] cfg_q;

  assign cfg      = cfg_q;
  assign restart  = cmd_valid;
  assign wr_evt   = cmd_valid && cmd_write;
  assign load_cfg = cmd_write ? cmd_wdata : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_evt) begin
      cfg_q <= cmd_wdata;
    end else if (clr_cfg) begin
      cfg_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cmd_valid && !cmd_write;
      if (cmd_valid && !cmd_write) begin
        rsp_rdata <= cfg_q;
      end
    end
  end

endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  expiry_t evt,
  input  logic    wr_evt,
  output logic    clr_cfg,
  output logic    tmo_flag,
  output logic    rst_req,
  output logic    irq,
  output logic    cent_clr
);

  logic to_rst;
  logic to_irq;

  assign to_rst  = evt.fire && (evt.route == STEER_RST);
  assign to_irq  = evt.fire && (evt.route == STEER_IRQ);
  assign clr_cfg = to_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_flag <= 1'b0;
      rst_req  <= 1'b0;
      irq      <= 1'b0;
      cent_clr <= 1'b0;
    end else begin
      rst_req  <= to_rst;
      cent_clr <= to_rst;
      irq      <= to_irq;
      if (wr_evt) begin
        tmo_flag <= 1'b0;
      end else if (evt.fire) begin
        tmo_flag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_encoded.sv
module wdt_encoded
  import wdt_pkg::*;
#(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int CFG_W = 1 + MULT_W + RES_W,
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [CFG_W-1:0] cmd_wdata,
  output logic             rsp_valid,
  output logic [CFG_W-1:0] rsp_rdata,
  output logic             rst_req,
  output logic             irq,
  output logic             cent_clr,
  output logic             tmo_flag
);

  logic [CFG_W-1:0] cfg;
  logic [CFG_W-1:0] load_cfg;
  logic [CNT_W-1:0] load_ticks;
  logic             load_zero;
  logic             restart;
  logic             wr_evt;
  logic             clr_cfg;
  logic             expire;
  expiry_t          evt;

  assign cmd_ready = 1'b1;

  wdt_regif #(.CFG_W(CFG_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_wdata (cmd_wdata),
    .clr_cfg   (clr_cfg),
    .cfg       (cfg),
    .load_cfg  (load_cfg),
    .restart   (restart),
    .wr_evt    (wr_evt),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  wdt_decode #(.MULT_W(MULT_W), .RES_W(RES_W)) u_decode (
    .cfg   (load_cfg),
    .ticks (load_ticks),
    .zero  (load_zero)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .load      (load_ticks),
    .load_zero (load_zero),
    .tick      (tick),
    .expire    (expire)
  );

  assign evt.fire  = expire;
  assign evt.route = steer_e'(cfg[CFG_W-1]);

  wdt_steer u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .wr_evt   (wr_evt),
    .clr_cfg  (clr_cfg),
    .tmo_flag (tmo_flag),
    .rst_req  (rst_req),
    .irq      (irq),
    .cent_clr (cent_clr)
  );

endmodule

// File: rtl/wdt_encoded_chk.sv
module wdt_encoded_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_write,
  input logic rsp_valid,
  input logic rst_req,
  input logic irq,
  input logic cent_clr,
  input logic tmo_flag
);

  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |=> !tmo_flag);

  assert_rsp_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && !cmd_write));

  assert_flag_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || irq) |-> tmo_flag);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !(cmd_valid && cmd_write)) |=> tmo_flag);

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_rst_with_cent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cent_clr);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));

  assert_restart_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !(rst_req || irq));

endmodule

bind wdt_encoded wdt_encoded_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .rsp_valid (rsp_valid),
  .rst_req   (rst_req),
  .irq       (irq),
  .cent_clr  (cent_clr),
  .tmo_flag  (tmo_flag)
);

// File: tb/wdt_encoded_tb_top.sv
module wdt_encoded_tb_top;

  localparam int CLK_P = 10;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_ready;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       rst_req;
  logic       irq;
  logic       cent_clr;
  logic       tmo_flag;

  always #(CLK_P/2) clk = ~clk;

  wdt_encoded dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rst_req   (rst_req),
    .irq       (irq),
    .cent_clr  (cent_clr),
    .tmo_flag  (tmo_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_on = 0;
  bit done   = 0;
  int n_irq = 0, n_rst = 0, n_cc = 0;
  logic [7:0] last_rd = 8'h00;

  // Behavioural reference: remaining ticks as an integer, 0 = stopped.
  int   m_ctrl = 0, m_cnt = 0;
  bit   m_flag = 0, e_rst = 0, e_irq = 0, e_cc = 0, e_rv = 0;
  int   e_rd = 0;

  function automatic int interval(int v);
    return ((v >> 2) & 31) * (1 << (2 * (v & 3)));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_flag = 0;
      e_rst = 0; e_irq = 0; e_cc = 0; e_rv = 0; e_rd = 0;
    end else begin
      e_rst = 0; e_irq = 0; e_cc = 0; e_rv = 0;
      if (cmd_valid) begin
        if (cmd_write) begin
          m_ctrl = cmd_wdata; m_flag = 0; m_cnt = interval(cmd_wdata);
        end else begin
          e_rv = 1; e_rd = m_ctrl; m_cnt = interval(m_ctrl);
        end
      end else if (tick && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_flag = 1;
          if (m_ctrl[7]) begin e_rst = 1; e_cc = 1; m_ctrl = 0; end
          else e_irq = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      if (rst_req) n_rst++;
      if (irq) n_irq++;
      if (cent_clr) n_cc++;
      if (rsp_valid) last_rd = rsp_rdata;
      chk(rst_req == e_rst, "R6 rst_req", rst_req, e_rst);
      chk(cent_clr == e_cc, "R6 cent_clr", cent_clr, e_cc);
      chk(irq == e_irq, "R7 irq", irq, e_irq);
      chk(tmo_flag == m_flag, "R5 tmo_flag", tmo_flag, m_flag);
      chk(rsp_valid == e_rv, "R4 rsp_valid", rsp_valid, e_rv);
      if (e_rv) chk(rsp_rdata == 8'(e_rd), "R4 rsp_rdata", rsp_rdata, e_rd);
      chk(cmd_ready == 1'b1, "R10 cmd_ready", cmd_ready, 1);
    end
  end

  task automatic drive(input bit v, input bit w, input logic [7:0] d, input bit t);
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_wdata = d; tick = t;
  endtask

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, (i % every) == 0);
  endtask

  task automatic settle();
    drive(0, 0, 8'h00, 0);
    drive(0, 0, 8'h00, 0);
    @(negedge clk); #(CLK_P/4);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, LIMIT);
      summary();
    end
  end

  initial begin
    int bi, br, bc;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(tmo_flag == 0 && rst_req == 0 && irq == 0 && cent_clr == 0 && rsp_valid == 0,
        "R11 reset outputs", {tmo_flag, rst_req, irq, cent_clr, rsp_valid}, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    drive(1, 0, 8'h00, 0); settle();
    chk(last_rd == 8'h00, "R11 reset byte", last_rd, 0);
    run(50, 1); settle();
    chk(n_irq + n_rst == 0, "R11 disabled after reset", n_irq + n_rst, 0);

    // R1/R7: 0x05 -> mult 1, res 1 -> 4 ticks, interrupt route
    bi = n_irq;
    drive(1, 1, 8'h05, 0); run(3, 1); settle();
    chk(n_irq == bi, "R1 no early expiry", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi + 1, "R1 expiry on 4th tick", n_irq - bi, 1);
    chk(tmo_flag == 1, "R5 flag set", tmo_flag, 1);
    // R8: stopped afterwards
    run(40, 1); settle();
    chk(n_irq == bi + 1, "R8 no repeat", n_irq - bi, 1);
    drive(1, 0, 8'h00, 0); settle();
    chk(last_rd == 8'h05, "R7 byte kept", last_rd, 8'h05);
    chk(tmo_flag == 1, "R4 read keeps flag", tmo_flag, 1);

    // R2/R3: zero disables; write clears flag
    bi = n_irq; br = n_rst;
    drive(1, 1, 8'h00, 0); settle();
    chk(tmo_flag == 0, "R3 write clears flag", tmo_flag, 0);
    run(200, 1);
    drive(1, 1, 8'h83, 0); run(300, 1); settle();
    chk(n_irq == bi && n_rst == br, "R2 zero multiplier disabled", n_irq + n_rst - bi - br, 0);

    // R6: 0x88 -> reset route, 2 ticks
    br = n_rst; bc = n_cc;
    drive(1, 1, 8'h88, 0); run(2, 1); settle();
    chk(n_rst == br + 1, "R6 reset pulse", n_rst - br, 1);
    chk(n_cc == bc + 1, "R6 century clear", n_cc - bc, 1);
    drive(1, 0, 8'h00, 0); settle();
    chk(last_rd == 8'h00, "R6 byte cleared", last_rd, 0);

    // R3: rewrite mid-count with a new interval
    bi = n_irq;
    drive(1, 1, 8'h10, 0); run(3, 1);   // 4 ticks, 3 used
    drive(1, 1, 8'h08, 0); run(1, 1); settle();
    chk(n_irq == bi, "R3 restart with new value", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi + 1, "R3 new interval expires", n_irq - bi, 1);

    // R9: read with the final tick in the same clock
    bi = n_irq;
    drive(1, 1, 8'h08, 0); run(1, 1);
    drive(1, 0, 8'h00, 1); settle();
    chk(n_irq == bi, "R9 restart wins", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi, "R9 full interval again", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi + 1, "R9 expiry after restart", n_irq - bi, 1);

    // R4: read restarts using stored value (3 ticks)
    bi = n_irq;
    drive(1, 1, 8'h0C, 0); run(2, 1);
    drive(1, 0, 8'h00, 0); run(2, 1); settle();
    chk(n_irq == bi, "R4 read restarted", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi + 1, "R4 expiry after read", n_irq - bi, 1);

    // R1: largest interval 0x7F -> 1984 ticks, sparse ticks for res 2
    bi = n_irq;
    drive(1, 1, 8'h7F, 0); run(1983, 1); settle();
    chk(n_irq == bi, "R1 max interval early", n_irq - bi, 0);
    run(1, 1); settle();
    chk(n_irq == bi + 1, "R1 max interval", n_irq - bi, 1);
    bi = n_irq;
    drive(1, 1, 8'h06, 0); run(16 * 3, 3); settle();
    chk(n_irq == bi + 1, "R1 sparse ticks res 2", n_irq - bi, 1);

    done = 1;
    summary();
  end

endmodule